// File: doc/BRIEF.md
# Auxiliary-Channel Transaction Framer and Reply Classifier

This block turns one auxiliary-channel request into the byte stream a line coder sends, and then turns the bytes that come back into a verdict. A caller gives a 4-bit command, a 20-bit address, a payload length, an optional write payload and a start delay. The block packs a header and, for write commands, the payload into a transmit buffer. It clears any stale completion flag, waits out the delay and raises a one-cycle go pulse. The line coder drains the transmit buffer through an auto-incrementing read port. It fills the reply buffer through an auto-incrementing write port and then pulses a done strobe that carries seven condition flags.

Once done is seen, the block classifies the reply in a fixed order of precedence. The order is disconnect, then timeout, then symbol errors, then an empty reply, then the reply code. For an acknowledged read whose payload fits the caller's capacity, it streams the payload bytes out. It then pulses a completion strobe with the status, the reply kind and the payload length. Manchester line coding, arbitration for the channel and retry policy belong to neighbouring blocks.

Top module: `aux_xact_engine`

## Requirements
- R1: The first three transmitted bytes are {command, address[19:16]}, then address[15:8], then address[7:0].
- R2: A fourth header byte equal to length minus one is transmitted only when the request length is nonzero.
- R3: `ln_txcnt` equals 3 for a zero length and 4 otherwise, plus the length when the command is a write. Write commands are 4'h8 (native write), 4'h0 (I2C write) and 4'h4 (I2C write, middle of transaction). After the header, the payload bytes follow in order, byte 0 taken from `req_wdata[7:0]`.
- R4: The first cycle after acceptance is cycle 1. `ln_go` rises in cycle txcnt + delay + 4, lasts one cycle, and is never high while the done flag is set. A done flag left over from earlier is acknowledged before go.
- R5: The internal done flag sets on `ln_done` and stays set until the block acknowledges it at the start of the next request. Flags from a stale done never affect the next result.
- R6: The reply code is `rx byte0[7:4]`. Code 0 gives kind 0 (ACK), 1 gives kind 1 (NACK), 2 gives kind 2 (DEFER), 4 gives kind 3 (I2C NACK) and 8 gives kind 4 (I2C DEFER), each with status 0 (success). Any other code gives status 2 (invalid) and kind 5.
- R7: The reply count includes the code byte. A count of 0 gives status 2. For an ACK, `rsp_len` is the count minus one and exactly that many payload bytes stream on `rsp_byte`. Other kinds report length 0.
- R8: Flag bit 0 (disconnect) yields status 3 over every other condition.
- R9: Flag bit 1 or bit 2 (receive timeout) yields status 1 unless bit 0 is set.
- R10: Flag bits 3 to 6 (invalid stop, no receive detect, invalid high, invalid low) yield status 2 when bits 0 to 2 are clear.
- R11: An ACK payload longer than `req_cap` gives status 4 (oversize) with length 0, and no byte is streamed.
- R12: `req_ready` is high only when idle. A `req_valid` while busy is ignored and leaves the frame in progress unchanged. Whenever status is not 0, kind reads 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when ready |
| req_ready | output | 1 | Block idle |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 20 | Target address |
| req_len | input | LENW | Payload length, 0 to PAY_MAX |
| req_wdata | input | PAY_MAX*8 | Write payload, byte 0 lowest |
| req_delay | input | DLYW | Extra cycles before go |
| req_cap | input | CNTW | Largest payload the caller accepts |
| ln_go | output | 1 | Start pulse to the line coder |
| ln_txcnt | output | CNTW | Bytes to transmit |
| ln_tx_re | input | 1 | Transmit byte taken, advance index |
| ln_tx_byte | output | 8 | Transmit byte at current index |
| ln_rx_we | input | 1 | Reply byte write, advance index |
| ln_rx_byte | input | 8 | Reply byte |
| ln_done | input | 1 | Reply complete or timed out |
| ln_flags | input | 7 | Condition flags, valid with done |
| rsp_valid | output | 1 | Payload byte valid |
| rsp_byte | output | 8 | Payload byte |
| rsp_done | output | 1 | Result strobe |
| rsp_status | output | 3 | 0 ok, 1 timeout, 2 invalid, 3 disconnect, 4 oversize |
| rsp_kind | output | 3 | Decoded reply kind |
| rsp_len | output | CNTW | Payload length reported |

## Verification
The hardest case to reach from the ports is a completion flag that is already set when a new request arrives. The bench pulses `ln_done` with the disconnect flag raised while the block is idle. It then runs an ordinary acknowledged read and expects success, the fresh payload and the usual go timing. In the same transaction it raises `req_valid` with a different command while the frame is loading, and checks every transmitted byte against the first request. Flag combinations are chosen in pairs so that each step of the precedence chain is decided by exactly one flag.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

  localparam int FL_HPD     = 0;
  localparam int FL_TO_ST   = 1;
  localparam int FL_TO      = 2;
  localparam int FL_BADSTOP = 3;
  localparam int FL_NODET   = 4;
  localparam int FL_BADH    = 5;
  localparam int FL_BADL    = 6;
  localparam int FLAG_W     = 7;

  typedef enum logic [2:0] {
    XS_OK       = 3'd0,
    XS_TIMEOUT  = 3'd1,
    XS_INVALID  = 3'd2,
    XS_HPD      = 3'd3,
    XS_OVERSIZE = 3'd4
  } xact_status_e;

  typedef enum logic [2:0] {
    RK_ACK      = 3'd0,
    RK_NACK     = 3'd1,
    RK_DEFER    = 3'd2,
    RK_I2C_NACK = 3'd3,
    RK_I2C_DEF  = 3'd4,
    RK_BAD      = 3'd5
  } reply_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_ACK, S_WCLR, S_DELAY, S_GO, S_WAIT, S_CLASS, S_READ, S_FIN
  } eng_state_e;

endpackage

// File: rtl/aux_idx_buf.sv
module aux_idx_buf #(
  parameter int DEPTH = 20,
  localparam int IW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [7:0]    wdata,
  input  logic          re,
  output logic [7:0]    rdata,
  output logic [IW-1:0] wr_cnt
);

  logic [IW-1:0]        wr_idx_q, wr_idx_d;
  logic [IW-1:0]        rd_idx_q, rd_idx_d;
  logic [DEPTH*8-1:0]   flat;
  logic                 wr_ok;

  assign wr_ok = we && (wr_idx_q < IW'(DEPTH));

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [7:0] ent_q;
      always_ff @(posedge clk) begin
        if (wr_ok && (wr_idx_q == IW'(g))) ent_q <= wdata;
      end
      assign flat[g*8 +: 8] = ent_q;
    end
  endgenerate

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_q == IW'(i)) rdata = flat[i*8 +: 8];
    end
  end

  always_comb begin
    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    if (clr) begin
      wr_idx_d = '0;
      rd_idx_d = '0;
    end else begin
      if (wr_ok) wr_idx_d = wr_idx_q + 1'b1;
      if (re && (rd_idx_q < IW'(DEPTH))) rd_idx_d = rd_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
    end
  end

  assign wr_cnt = wr_idx_q;

endmodule

// File: rtl/aux_hdr_enc.sv
module aux_hdr_enc #(
  parameter int DEPTH   = 20,
  parameter int PAY_MAX = 16,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int LENW = $clog2(PAY_MAX + 1)
) (
  input  logic [3:0]           cmd,
  input  logic [19:0]          addr,
  input  logic [LENW-1:0]      len,
  input  logic [PAY_MAX*8-1:0] wdata,
  input  logic [CNTW-1:0]      idx,
  output logic [7:0]           byte_o,
  output logic [CNTW-1:0]      total
);

  logic            is_wr;
  logic [CNTW-1:0] hdr_n;
  logic [CNTW-1:0] pidx;
  logic [7:0]      pbyte;

  assign is_wr = (cmd == 4'h8) || (cmd == 4'h0) || (cmd == 4'h4);
  assign hdr_n = (len != '0) ? CNTW'(4) : CNTW'(3);
  assign total = hdr_n + (is_wr ? CNTW'(len) : CNTW'(0));
  assign pidx  = idx - hdr_n;

  always_comb begin
    pbyte = 8'h00;
    for (int i = 0; i < PAY_MAX; i++) begin
      if (pidx == CNTW'(i)) pbyte = wdata[i*8 +: 8];
    end
  end

  always_comb begin
    unique case (idx)
      CNTW'(0): byte_o = {cmd, addr[19:16]};
      CNTW'(1): byte_o = addr[15:8];
      CNTW'(2): byte_o = addr[7:0];
      CNTW'(3): byte_o = (len != '0) ? 8'(len - 1'b1) : pbyte;
      default:  byte_o = pbyte;
    endcase
  end

endmodule

// File: rtl/aux_reply_cls.sv
module aux_reply_cls
  import aux_xact_pkg::*;
#(
  parameter int DEPTH = 20,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [CNTW-1:0]   cnt,
  input  logic [7:0]        code_byte,
  input  logic [CNTW-1:0]   cap,
  output xact_status_e      status,
  output reply_kind_e       kind,
  output logic [CNTW-1:0]   plen
);

  logic [CNTW-1:0] body;

  assign body = cnt - 1'b1;

  always_comb begin
    status = XS_OK;
    kind   = RK_BAD;
    plen   = '0;
    if (flags[FL_HPD]) begin
      status = XS_HPD;
    end else if (flags[FL_TO_ST] || flags[FL_TO]) begin
      status = XS_TIMEOUT;
    end else if (flags[FL_BADSTOP] || flags[FL_NODET] || flags[FL_BADH] || flags[FL_BADL]) begin
      status = XS_INVALID;
    end else if (cnt == '0) begin
      status = XS_INVALID;
    end else begin
      unique case (code_byte[7:4])
        4'h0: begin
          if (body > cap) begin
            status = XS_OVERSIZE;
          end else begin
            kind = RK_ACK;
            plen = body;
          end
        end
        4'h1:    kind = RK_NACK;
        4'h2:    kind = RK_DEFER;
        4'h4:    kind = RK_I2C_NACK;
        4'h8:    kind = RK_I2C_DEF;
        default: status = XS_INVALID;
      endcase
    end
  end

endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
  import aux_xact_pkg::*;
#(
  parameter int DEPTH   = 20,
  parameter int PAY_MAX = 16,
  parameter int DLYW    = 4,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int LENW = $clog2(PAY_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [3:0]           req_cmd,
  input  logic [19:0]          req_addr,
  input  logic [LENW-1:0]      req_len,
  input  logic [PAY_MAX*8-1:0] req_wdata,
  input  logic [DLYW-1:0]      req_delay,
  input  logic [CNTW-1:0]      req_cap,
  output logic                 ln_go,
  output logic [CNTW-1:0]      ln_txcnt,
  input  logic                 ln_tx_re,
  output logic [7:0]           ln_tx_byte,
  input  logic                 ln_rx_we,
  input  logic [7:0]           ln_rx_byte,
  input  logic                 ln_done,
  input  logic [6:0]           ln_flags,
  output logic                 rsp_valid,
  output logic [7:0]           rsp_byte,
  output logic                 rsp_done,
  output logic [2:0]           rsp_status,
  output logic [2:0]           rsp_kind,
  output logic [CNTW-1:0]      rsp_len
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  eng_state_e            st_q, st_d;
  logic [3:0]            cmd_q;
  logic [19:0]           addr_q;
  logic [LENW-1:0]       len_q;
  logic [PAY_MAX*8-1:0]  wdata_q;
  logic [DLYW-1:0]       dly_q;
  logic [CNTW-1:0]       cap_q;
  logic                  req_en;

  logic [CNTW-1:0]       hidx_q, hidx_d;
  logic [DLYW-1:0]       dcnt_q, dcnt_d;
  logic [CNTW-1:0]       rcnt_q, rcnt_d;
  logic                  done_q, done_d, done_ack;
  logic [FLAG_W-1:0]     flags_q;

  xact_status_e          status_q, cls_status;
  reply_kind_e           kind_q, cls_kind;
  logic [CNTW-1:0]       plen_q, cls_plen;
  logic                  cls_en;

  logic [7:0]            enc_byte;
  logic [CNTW-1:0]       enc_total;
  logic                  tx_clr, tx_we;
  logic                  rx_clr, rx_re;
  logic [7:0]            rx_rdata;
  logic [CNTW-1:0]       rx_cnt;
  logic [CNTW-1:0]       tx_cnt_unused;

  aux_hdr_enc #(.DEPTH(DEPTH), .PAY_MAX(PAY_MAX)) u_enc (
    .cmd(cmd_q), .addr(addr_q), .len(len_q), .wdata(wdata_q),
    .idx(hidx_q), .byte_o(enc_byte), .total(enc_total)
  );

  aux_idx_buf #(.DEPTH(DEPTH)) u_txbuf (
    .clk(clk), .rst_n(rst_sn), .clr(tx_clr), .we(tx_we), .wdata(enc_byte),
    .re(ln_tx_re), .rdata(ln_tx_byte), .wr_cnt(tx_cnt_unused)
  );

  aux_idx_buf #(.DEPTH(DEPTH)) u_rxbuf (
    .clk(clk), .rst_n(rst_sn), .clr(rx_clr), .we(ln_rx_we), .wdata(ln_rx_byte),
    .re(rx_re), .rdata(rx_rdata), .wr_cnt(rx_cnt)
  );

  aux_reply_cls #(.DEPTH(DEPTH)) u_cls (
    .flags(flags_q), .cnt(rx_cnt), .code_byte(rx_rdata), .cap(cap_q),
    .status(cls_status), .kind(cls_kind), .plen(cls_plen)
  );

  assign req_en   = (st_q == S_IDLE) && req_valid;
  assign tx_clr   = req_en;
  assign tx_we    = (st_q == S_LOAD);
  assign rx_clr   = (st_q == S_GO);
  assign rx_re    = (st_q == S_CLASS) || (st_q == S_READ);
  assign done_ack = (st_q == S_ACK);
  assign cls_en   = (st_q == S_CLASS);

  // next state
  always_comb begin
    st_d   = st_q;
    hidx_d = hidx_q;
    dcnt_d = dcnt_q;
    rcnt_d = rcnt_q;
    unique case (st_q)
      S_IDLE:  if (req_valid) begin st_d = S_LOAD; hidx_d = '0; end
      S_LOAD: begin
        hidx_d = hidx_q + 1'b1;
        if (hidx_q == enc_total - 1'b1) st_d = S_ACK;
      end
      S_ACK:   st_d = S_WCLR;
      S_WCLR:  if (done_q) st_d = S_ACK; else begin st_d = S_DELAY; dcnt_d = dly_q; end
      S_DELAY: if (dcnt_q == '0) st_d = S_GO; else dcnt_d = dcnt_q - 1'b1;
      S_GO:    st_d = S_WAIT;
      S_WAIT:  if (done_q) st_d = S_CLASS;
      S_CLASS: begin
        rcnt_d = cls_plen;
        st_d   = (cls_status == XS_OK && cls_kind == RK_ACK && cls_plen != '0) ? S_READ : S_FIN;
      end
      S_READ: begin
        rcnt_d = rcnt_q - 1'b1;
        if (rcnt_q == CNTW'(1)) st_d = S_FIN;
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    done_d = done_ack ? 1'b0 : done_q;
    if (ln_done) done_d = 1'b1;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= S_IDLE;
      hidx_q <= '0;
      dcnt_q <= '0;
      rcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hidx_q <= hidx_d;
      dcnt_q <= dcnt_d;
      rcnt_q <= rcnt_d;
      done_q <= done_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cmd_q    <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      wdata_q  <= '0;
      dly_q    <= '0;
      cap_q    <= '0;
      flags_q  <= '0;
      status_q <= XS_OK;
      kind_q   <= RK_BAD;
      plen_q   <= '0;
    end else begin
      if (req_en) begin
        cmd_q   <= req_cmd;
        addr_q  <= req_addr;
        len_q   <= req_len;
        wdata_q <= req_wdata;
        dly_q   <= req_delay;
        cap_q   <= req_cap;
      end
      if (ln_done) flags_q <= ln_flags;
      if (cls_en) begin
        status_q <= cls_status;
        kind_q   <= cls_kind;
        plen_q   <= cls_plen;
      end
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign ln_go      = (st_q == S_GO);
  assign ln_txcnt   = enc_total;
  assign rsp_valid  = (st_q == S_READ);
  assign rsp_byte   = rx_rdata;
  assign rsp_done   = (st_q == S_FIN);
  assign rsp_status = status_q;
  assign rsp_kind   = kind_q;
  assign rsp_len    = plen_q;

endmodule

// File: rtl/aux_xact_engine_chk.sv
module aux_xact_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ln_go,
  input logic       ln_done,
  input logic       done_q,
  input logic       done_ack,
  input logic [6:0] flags_q,
  input logic       rsp_valid,
  input logic       rsp_done,
  input logic [2:0] rsp_status,
  input logic [2:0] rsp_kind,
  input logic       req_ready
);

  assert_go_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ln_go |-> !done_q);

  assert_go_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ln_go |=> !ln_go);

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ln_done |=> done_q);

  assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_ack) |=> done_q);

  assert_stream_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status == 3'd0 && rsp_kind == 3'd0));

  assert_hpd_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && flags_q[0]) |-> rsp_status == 3'd3);

  assert_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !flags_q[0] && (flags_q[1] || flags_q[2])) |-> rsp_status == 3'd1);

  assert_symbol_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && flags_q[2:0] == 3'b000 && flags_q[6:3] != 4'h0) |-> rsp_status == 3'd2);

  assert_idle_after_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready);

  assert_kind_bad_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status != 3'd0) |-> rsp_kind == 3'd5);

endmodule

bind aux_xact_engine aux_xact_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ln_go(ln_go), .ln_done(ln_done),
  .done_q(done_q), .done_ack(done_ack), .flags_q(flags_q),
  .rsp_valid(rsp_valid), .rsp_done(rsp_done), .rsp_status(rsp_status),
  .rsp_kind(rsp_kind), .req_ready(req_ready)
);

// File: tb/aux_xact_engine_bench.sv
`timescale 1ns/1ps
module aux_xact_engine_bench;

  localparam int DEPTH = 20, PAY_MAX = 16, DLYW = 4;
  localparam int CNTW = $clog2(DEPTH + 1), LENW = $clog2(PAY_MAX + 1);

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [3:0] req_cmd;
  logic [19:0] req_addr;
  logic [LENW-1:0] req_len;
  logic [PAY_MAX*8-1:0] req_wdata;
  logic [DLYW-1:0] req_delay;
  logic [CNTW-1:0] req_cap;
  logic ln_go, ln_tx_re, ln_rx_we, ln_done;
  logic [CNTW-1:0] ln_txcnt;
  logic [7:0] ln_tx_byte, ln_rx_byte;
  logic [6:0] ln_flags;
  logic rsp_valid, rsp_done;
  logic [7:0] rsp_byte;
  logic [2:0] rsp_status, rsp_kind;
  logic [CNTW-1:0] rsp_len;

  aux_xact_engine #(.DEPTH(DEPTH), .PAY_MAX(PAY_MAX), .DLYW(DLYW)) u_aux_xact_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_delay(req_delay), .req_cap(req_cap), .ln_go(ln_go), .ln_txcnt(ln_txcnt),
    .ln_tx_re(ln_tx_re), .ln_tx_byte(ln_tx_byte), .ln_rx_we(ln_rx_we),
    .ln_rx_byte(ln_rx_byte), .ln_done(ln_done), .ln_flags(ln_flags),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_done(rsp_done),
    .rsp_status(rsp_status), .rsp_kind(rsp_kind), .rsp_len(rsp_len)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, bad = 0, done_cnt = 0;
  bit live = 0, finished = 0;

  int    q_byte[$];
  int    q_st[$], q_kd[$], q_ln[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (live) begin
      if (rsp_valid) begin
        if (q_byte.size() == 0) chk(0, "R7", "unexpected payload byte", rsp_byte, -1);
        else begin
          int e;
          e = q_byte.pop_front();
          chk(rsp_byte == e[7:0], "R7", "payload byte", rsp_byte, e);
        end
      end
      if (rsp_done) begin
        if (q_st.size() == 0) chk(0, "R12", "unexpected completion", 1, 0);
        else begin
          int es, ek, el;
          string t;
          es = q_st.pop_front(); ek = q_kd.pop_front(); el = q_ln.pop_front(); t = q_tag.pop_front();
          chk(rsp_status == es[2:0], t, "status", rsp_status, es);
          chk(rsp_kind == ek[2:0], t, "kind", rsp_kind, ek);
          chk(rsp_len == el[CNTW-1:0], "R7", "length", rsp_len, el);
          chk(q_byte.size() == 0, "R7", "bytes left unstreamed", q_byte.size(), 0);
          q_byte.delete();
        end
        done_cnt++;
      end
    end
  end

  function automatic int kind_of(input int code);
    case (code)
      0: return 0; 1: return 1; 2: return 2; 4: return 3; 8: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic xact(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                      input int dly, input int cap, input int code, input int nrep,
                      input logic [6:0] flags, input string tag, input bit stale, input bit poke);
    logic [7:0] wb[PAY_MAX];
    logic [7:0] rb[DEPTH];
    logic [7:0] fr[DEPTH];
    int hdr, total, k, es, ek, el, prev;
    bit wr;
    for (int i = 0; i < PAY_MAX; i++) wb[i] = 8'(8'hA0 + i * 3 + len);
    for (int i = 0; i < DEPTH; i++) rb[i] = 8'(8'h11 + i * 7 + code);
    rb[0] = {code[3:0], 4'h9};
    wr = (cmd == 4'h8) || (cmd == 4'h0) || (cmd == 4'h4);
    hdr = (len != 0) ? 4 : 3;
    total = hdr + (wr ? len : 0);
    fr[0] = {cmd, addr[19:16]}; fr[1] = addr[15:8]; fr[2] = addr[7:0];
    fr[3] = 8'(len - 1);
    for (int i = 0; i < PAY_MAX; i++) if (hdr + i < DEPTH) fr[hdr + i] = wb[i];
    // expected result from the requirement rules
    es = 0; ek = 5; el = 0;
    if (flags[0]) es = 3;
    else if (flags[1] || flags[2]) es = 1;
    else if (flags[6:3] != 0) es = 2;
    else if (nrep == 0) es = 2;
    else if (kind_of(code) == 5) es = 2;
    else if (code == 0 && nrep - 1 > cap) es = 4;
    else begin
      ek = kind_of(code);
      if (code == 0) el = nrep - 1;
    end
    if (es == 0 && ek == 0) for (int i = 1; i <= el; i++) q_byte.push_back(rb[i]);
    q_st.push_back(es); q_kd.push_back(ek); q_ln.push_back(el); q_tag.push_back(tag);
    prev = done_cnt;

    if (stale) begin
      @(negedge clk); ln_flags = 7'h01; ln_done = 1'b1;
      @(negedge clk); ln_done = 1'b0; ln_flags = 7'h00;
    end
    @(negedge clk);
    req_cmd = cmd; req_addr = addr; req_len = LENW'(len); req_delay = DLYW'(dly); req_cap = CNTW'(cap);
    for (int i = 0; i < PAY_MAX; i++) req_wdata[i*8 +: 8] = wb[i];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    if (poke) begin
      chk(req_ready == 1'b0, "R12", "ready while busy", req_ready, 0);
      req_cmd = 4'h9; req_addr = ~addr; req_len = '0; req_valid = 1'b1;
    end
    while (!ln_go) begin
      @(negedge clk); k++;
      req_valid = 1'b0;
    end
    chk(k == total + dly + 4, "R4", "go cycle", k, total + dly + 4);
    chk(ln_txcnt == CNTW'(total), "R3", "tx count", ln_txcnt, total);
    @(negedge clk);
    chk(ln_go == 1'b0, "R4", "go width", ln_go, 0);
    for (int i = 0; i < total; i++) begin
      ln_tx_re = 1'b1;
      chk(ln_tx_byte == fr[i], (i < 3) ? "R1" : (i == 3 && len != 0) ? "R2" : "R3",
          $sformatf("tx byte %0d", i), ln_tx_byte, fr[i]);
      @(negedge clk);
    end
    ln_tx_re = 1'b0;
    for (int i = 0; i < nrep; i++) begin
      ln_rx_we = 1'b1; ln_rx_byte = rb[i];
      @(negedge clk);
    end
    ln_rx_we = 1'b0;
    ln_flags = flags; ln_done = 1'b1;
    @(negedge clk);
    ln_done = 1'b0; ln_flags = 7'h00;
    while (done_cnt == prev) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_len = '0;
    req_wdata = '0; req_delay = '0; req_cap = '0; ln_tx_re = 1'b0; ln_rx_we = 1'b0;
    ln_rx_byte = '0; ln_done = 1'b0; ln_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R12", "reset ready", req_ready, 1);
    chk(ln_go == 1'b0, "R4", "reset go", ln_go, 0);
    chk(rsp_valid == 1'b0 && rsp_done == 1'b0, "R7", "reset outputs", rsp_valid, 0);
    live = 1;

    xact(4'h9, 20'hA5C3E, 4, 0, 16, 0, 5, 7'h00, "R6", 0, 0);   // native read ACK
    xact(4'h8, 20'h12345, 3, 2, 16, 0, 1, 7'h00, "R3", 0, 0);   // native write
    xact(4'h4, 20'hF00D1, 0, 1, 16, 1, 1, 7'h00, "R2", 0, 0);   // I2C write MOT, zero length, NACK
    xact(4'h1, 20'h00050, 2, 0, 16, 2, 3, 7'h00, "R6", 0, 0);   // DEFER
    xact(4'h5, 20'h00050, 1, 0, 16, 4, 1, 7'h00, "R6", 0, 0);   // I2C NACK
    xact(4'h5, 20'h00050, 1, 0, 16, 8, 1, 7'h00, "R6", 0, 0);   // I2C DEFER
    xact(4'h9, 20'h00777, 1, 0, 16, 3, 2, 7'h00, "R6", 0, 0);   // unknown code
    xact(4'h9, 20'h00777, 1, 0, 16, 0, 0, 7'h00, "R7", 0, 0);   // empty reply
    xact(4'h9, 20'h00777, 1, 0, 16, 0, 3, 7'h05, "R8", 0, 0);   // disconnect over timeout
    xact(4'h9, 20'h00777, 1, 0, 16, 0, 3, 7'h0A, "R9", 0, 0);   // timeout-state over stop
    xact(4'h9, 20'h00777, 1, 0, 16, 0, 3, 7'h04, "R9", 0, 0);   // timeout
    xact(4'h9, 20'h00777, 1, 0, 16, 0, 3, 7'h20, "R10", 0, 0);  // invalid high symbol
    xact(4'h9, 20'h00777, 1, 0, 16, 0, 3, 7'h50, "R10", 0, 0);  // no detect + invalid low
    xact(4'h9, 20'h3ABCD, 8, 0, 3, 0, 6, 7'h00, "R11", 0, 0);   // oversize
    xact(4'h9, 20'h3ABCD, 8, 0, 5, 0, 6, 7'h00, "R11", 0, 0);   // exactly fits
    xact(4'h9, 20'h6E0F2, 2, 3, 16, 0, 3, 7'h00, "R5", 1, 1);   // stale done + busy poke
    xact(4'h0, 20'hFFFFF, 16, 0, 16, 0, 1, 7'h00, "R3", 0, 0);  // full-length I2C write

    repeat (3) @(negedge clk);
    chk(q_st.size() == 0, "R12", "completions missing", q_st.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; bad++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", done_cnt, 17);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule